// File: doc/BRIEF.md
# Base-Limit Segment Register Translator

This block turns a logical address, made of a segment index and an offset, into a physical address. It uses a small bank of base/limit register pairs. There are no tables in memory and no paging. Every access selects one pair and checks the offset against that pair's limit. It also checks the pair's permission bit for the kind of access. If both checks pass, the block drives out base plus offset; if either fails, it reports a fault and blocks the access. The path from request to result is combinational: one comparison and one addition.

The selected pair comes either from an explicit index field on the request or, when implicit selection is on, from the processor mode and whether the access is an instruction fetch. Software running in kernel mode loads a pair, its limit and its three permission bits in one write. A write made in user mode changes nothing and raises a privilege error one cycle later. A registered status output keeps the cause and the offset of the most recent faulting request for one cycle.

Top module: `segxlate`

## Requirements
- R1: A request whose offset is strictly less than the selected pair's limit, and whose permission bit is set, raises `grant` and drives `phys_addr` equal to base plus zero-extended offset, truncated to ADDR_W bits.
- R2: An offset equal to or greater than the selected pair's limit raises `fault_bound`, keeps `grant` low and drives `phys_addr` to zero.
- R3: The permission bits of each pair are: bit 0 allows read, bit 1 allows write, bit 2 allows fetch. `req_type` is coded 00 read, 01 write, 10 fetch and 11 reserved. A reserved type always fails. An in-bounds request whose bit is clear raises `fault_perm` and keeps `grant` low.
- R4: When the bound check and the permission check both fail, only `fault_bound` is raised.
- R5: With `implicit_en` high, the pair index is {kernel, fetch}: 0 for user data, 1 for user fetch, 2 for kernel data and 3 for kernel fetch. `req_sel` is ignored.
- R6: With `implicit_en` low, `req_sel` selects the pair, whatever the mode.
- R7: A kernel-mode write (`wr_en` with `kernel` high) loads the base, the limit and the permissions of pair `wr_idx` together at the clock edge. The new values apply from the next cycle on.
- R8: A user-mode write leaves every pair unchanged. It sets `priv_err` high in the following cycle.
- R9: In the cycle after a faulting request, `fst_valid` is 1, `fst_cause` is 01 for a bound fault or 10 for a permission fault, and `fst_off` holds the offset. After a cycle with no fault, `fst_valid` is 0 and `fst_cause` is 00.
- R10: After reset, every pair has base 0, limit 0 and no permissions, so any access is a bound fault. `fst_valid` and `priv_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kernel | input | 1 | Processor mode, 1 for kernel |
| wr_en | input | 1 | Register pair write strobe |
| wr_idx | input | SEL_W | Pair to write |
| wr_base | input | ADDR_W | New base |
| wr_limit | input | OFF_W+1 | New limit |
| wr_perm | input | 3 | New permissions {fetch, write, read} |
| req_valid | input | 1 | Access request present |
| implicit_en | input | 1 | Select the pair from mode and access kind |
| req_sel | input | SEL_W | Explicit pair index |
| req_off | input | OFF_W | Offset in segment |
| req_type | input | 2 | Access kind |
| grant | output | 1 | Access allowed |
| phys_addr | output | ADDR_W | Translated address, zero when blocked |
| fault_bound | output | 1 | Offset at or past limit |
| fault_perm | output | 1 | Permission missing |
| fst_valid | output | 1 | Registered: last request faulted |
| fst_cause | output | 2 | Registered fault cause |
| fst_off | output | OFF_W | Registered faulting offset |
| priv_err | output | 1 | Registered: user-mode write attempted |

## Verification
The hardest case to reach is a user-mode write followed by proof that it left the bank untouched. The write changes no output directly. The stimulus first loads a pair in kernel mode, then sends a user write with different values to the same pair, and then translates through that pair. The expected address, bound result and permission result must all follow the earlier kernel values. A second hard case is a request that fails both checks: a write to a read-only pair with an offset past the limit, which must report only the bound cause, both at once and in the registered status.

// File: rtl/segxlate.sv
module segxlate #(
  parameter int NSEG   = 8,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        kernel,
  input  logic                        wr_en,
  input  logic [$clog2(NSEG)-1:0]     wr_idx,
  input  logic [ADDR_W-1:0]           wr_base,
  input  logic [OFF_W:0]              wr_limit,
  input  logic [2:0]                  wr_perm,
  input  logic                        req_valid,
  input  logic                        implicit_en,
  input  logic [$clog2(NSEG)-1:0]     req_sel,
  input  logic [OFF_W-1:0]            req_off,
  input  logic [1:0]                  req_type,
  output logic                        grant,
  output logic [ADDR_W-1:0]           phys_addr,
  output logic                        fault_bound,
  output logic                        fault_perm,
  output logic                        fst_valid,
  output logic [1:0]                  fst_cause,
  output logic [OFF_W-1:0]            fst_off,
  output logic                        priv_err
);
  localparam int SEL_W = $clog2(NSEG);
  localparam int LIM_W = OFF_W + 1;

  logic [ADDR_W-1:0] base_q [NSEG];
  logic [LIM_W-1:0]  lim_q  [NSEG];
  logic [2:0]        perm_q [NSEG];

  logic              wr_ok;
  logic              is_fetch;
  logic [SEL_W-1:0]  imp_idx;
  logic [SEL_W-1:0]  idx;
  logic              idx_ok;
  logic              perm_ok;
  logic [2:0]        sel_perm;

  assign wr_ok    = wr_en & kernel;
  assign is_fetch = (req_type == 2'b10);

  for (genvar i = 0; i < NSEG; i++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
        perm_q[i] <= '0;
      end else if (wr_ok && wr_idx == SEL_W'(i)) begin
        base_q[i] <= wr_base;
        lim_q[i]  <= wr_limit;
        perm_q[i] <= wr_perm;
      end
    end
  end

  if (NSEG >= 4) begin : g_imp4
    assign imp_idx = SEL_W'({kernel, is_fetch});
  end else begin : g_imp2
    assign imp_idx = SEL_W'(is_fetch);
  end

  assign idx      = implicit_en ? imp_idx : req_sel;
  assign idx_ok   = ({1'b0, idx} < (SEL_W+1)'(NSEG));
  assign sel_perm = idx_ok ? perm_q[idx] : 3'b000;

  always_comb begin
    case (req_type)
      2'b00:   perm_ok = sel_perm[0];
      2'b01:   perm_ok = sel_perm[1];
      2'b10:   perm_ok = sel_perm[2];
      default: perm_ok = 1'b0;
    endcase
  end

  assign fault_bound = req_valid & (~idx_ok | ({1'b0, req_off} >= lim_q[idx]));
  assign fault_perm  = req_valid & ~fault_bound & ~perm_ok;
  assign grant       = req_valid & ~fault_bound & ~fault_perm;
  assign phys_addr   = grant ? (base_q[idx] + ADDR_W'(req_off)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst_valid <= 1'b0;
      fst_cause <= 2'b00;
      fst_off   <= '0;
      priv_err  <= 1'b0;
    end else begin
      fst_valid <= fault_bound | fault_perm;
      fst_cause <= {fault_perm, fault_bound};
      if (fault_bound | fault_perm) fst_off <= req_off;
      priv_err  <= wr_en & ~kernel;
    end
  end
endmodule

// File: rtl/segxlate_chk.sv
module segxlate_chk #(
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              kernel,
  input logic              wr_en,
  input logic              req_valid,
  input logic [OFF_W-1:0]  req_off,
  input logic              grant,
  input logic [ADDR_W-1:0] phys_addr,
  input logic              fault_bound,
  input logic              fault_perm,
  input logic              fst_valid,
  input logic [1:0]        fst_cause,
  input logic [OFF_W-1:0]  fst_off,
  input logic              priv_err
);
  a_r2_bound_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fault_bound |-> (!grant && phys_addr == '0));

  a_r3_perm_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fault_perm |-> (!grant && phys_addr == '0));

  a_r4_bound_first: assert property (@(posedge clk) disable iff (!rst_n)
    fault_bound |-> !fault_perm);

  a_r9_status_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fault_bound |=> (fst_valid && fst_cause == 2'b01 && fst_off == $past(req_off)));

  a_r9_status_perm: assert property (@(posedge clk) disable iff (!rst_n)
    fault_perm |=> (fst_valid && fst_cause == 2'b10 && fst_off == $past(req_off)));

  a_r9_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!fst_valid && fst_cause == 2'b00));

  a_r8_priv_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !kernel) |=> priv_err);
endmodule

bind segxlate segxlate_chk #(.OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .kernel(kernel), .wr_en(wr_en),
  .req_valid(req_valid), .req_off(req_off), .grant(grant),
  .phys_addr(phys_addr), .fault_bound(fault_bound), .fault_perm(fault_perm),
  .fst_valid(fst_valid), .fst_cause(fst_cause), .fst_off(fst_off),
  .priv_err(priv_err)
);

// File: tb/tb_segxlate.sv
`timescale 1ns/1ps
module tb_segxlate;
  localparam int NSEG = 8, OFF_W = 16, ADDR_W = 24, SEL_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic kernel = 1'b0, wr_en = 1'b0, req_valid = 1'b0, implicit_en = 1'b0;
  logic [SEL_W-1:0] wr_idx = '0, req_sel = '0;
  logic [ADDR_W-1:0] wr_base = '0;
  logic [OFF_W:0] wr_limit = '0;
  logic [2:0] wr_perm = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [1:0] req_type = '0;
  logic grant, fault_bound, fault_perm, fst_valid, priv_err;
  logic [ADDR_W-1:0] phys_addr;
  logic [1:0] fst_cause;
  logic [OFF_W-1:0] fst_off;

  segxlate #(.NSEG(NSEG), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) dut (.*);

  always #4 clk = ~clk;

  typedef struct {
    string tag;
    logic g, fb, fp;
    logic [ADDR_W-1:0] pa;
    logic fv;
    logic [1:0] fc;
    logic [OFF_W-1:0] fo;
    logic pe;
  } item_t;
  item_t q[$];

  int checks = 0, errors = 0;
  logic [ADDR_W-1:0] mbase [NSEG];
  logic [OFF_W:0] mlim [NSEG];
  logic [2:0] mperm [NSEG];
  logic pv_fv = 0, pv_pe = 0;
  logic [1:0] pv_fc = 0;
  logic [OFF_W-1:0] pv_fo = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push_cycle(string tag, logic g, logic fb, logic fp, logic [ADDR_W-1:0] pa);
    item_t it;
    it.tag = tag; it.g = g; it.fb = fb; it.fp = fp; it.pa = pa;
    it.fv = pv_fv; it.fc = pv_fc; it.fo = pv_fo; it.pe = pv_pe;
    q.push_back(it);
  endtask

  task automatic wr(logic k, int idx, logic [ADDR_W-1:0] b, logic [OFF_W:0] l, logic [2:0] p, string tag);
    @(posedge clk); #1;
    req_valid = 0; wr_en = 1; kernel = k; wr_idx = SEL_W'(idx);
    wr_base = b; wr_limit = l; wr_perm = p;
    push_cycle(tag, 0, 0, 0, '0);
    pv_fv = 0; pv_fc = 0; pv_pe = !k;
    if (k) begin mbase[idx] = b; mlim[idx] = l; mperm[idx] = p; end
  endtask

  task automatic idle(string tag);
    @(posedge clk); #1;
    req_valid = 0; wr_en = 0;
    push_cycle(tag, 0, 0, 0, '0);
    pv_fv = 0; pv_fc = 0; pv_pe = 0;
  endtask

  task automatic acc(logic k, logic imp, int sel, logic [OFF_W-1:0] off, logic [1:0] typ, string tag);
    int idx;
    logic fb, fp, pok, g;
    logic [ADDR_W-1:0] pa;
    @(posedge clk); #1;
    wr_en = 0; req_valid = 1; kernel = k; implicit_en = imp;
    req_sel = SEL_W'(sel); req_off = off; req_type = typ;
    idx = imp ? (int'(k) * 2 + int'(typ == 2'b10)) : sel;
    fb = ({1'b0, off} >= mlim[idx]);
    case (typ)
      2'b00: pok = mperm[idx][0];
      2'b01: pok = mperm[idx][1];
      2'b10: pok = mperm[idx][2];
      default: pok = 0;
    endcase
    fp = !fb && !pok;
    g = !fb && !fp;
    pa = g ? ADDR_W'(mbase[idx] + ADDR_W'(off)) : '0;
    push_cycle(tag, g, fb, fp, pa);
    pv_fv = fb | fp; pv_fc = {fp, fb}; pv_pe = 0;
    if (fb | fp) pv_fo = off;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(it.tag, "grant", 32'(grant), 32'(it.g));
        chk(it.tag, "fault_bound", 32'(fault_bound), 32'(it.fb));
        chk(it.tag, "fault_perm", 32'(fault_perm), 32'(it.fp));
        chk(it.tag, "phys_addr", 32'(phys_addr), 32'(it.pa));
        chk("R9", "fst_valid", 32'(fst_valid), 32'(it.fv));
        chk("R9", "fst_cause", 32'(fst_cause), 32'(it.fc));
        if (it.fv) chk("R9", "fst_off", 32'(fst_off), 32'(it.fo));
        chk("R8", "priv_err", 32'(priv_err), 32'(it.pe));
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSEG; i++) begin mbase[i] = '0; mlim[i] = '0; mperm[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R10", "fst_valid in reset", 32'(fst_valid), 0);
    chk("R10", "priv_err in reset", 32'(priv_err), 0);
    rst_n = 1;
    acc(1, 0, 3, 16'h0000, 2'b00, "R10");
    wr(1, 0, 24'h001000, 17'h00100, 3'b001, "R7");
    wr(1, 1, 24'h002000, 17'h00080, 3'b100, "R7");
    wr(1, 2, 24'h400000, 17'h01000, 3'b011, "R7");
    wr(1, 3, 24'h500000, 17'h00200, 3'b101, "R7");
    wr(1, 5, 24'hFF0000, 17'h10000, 3'b111, "R7");
    wr(0, 0, 24'hABCDEF, 17'h0FFFF, 3'b111, "R8");
    acc(0, 0, 0, 16'h0010, 2'b00, "R8");
    acc(0, 0, 0, 16'h00FF, 2'b00, "R1");
    acc(0, 0, 0, 16'h0100, 2'b00, "R2");
    acc(0, 0, 0, 16'h8000, 2'b00, "R2");
    acc(0, 0, 0, 16'h0010, 2'b01, "R3");
    acc(0, 0, 0, 16'h0010, 2'b10, "R3");
    acc(0, 0, 0, 16'h0010, 2'b11, "R3");
    acc(0, 0, 0, 16'h0200, 2'b01, "R4");
    acc(1, 0, 5, 16'hFFFF, 2'b01, "R1");
    acc(0, 1, 7, 16'h0040, 2'b00, "R5");
    acc(0, 1, 7, 16'h0040, 2'b10, "R5");
    acc(1, 1, 0, 16'h0800, 2'b01, "R5");
    acc(1, 1, 0, 16'h0100, 2'b10, "R5");
    acc(1, 1, 0, 16'h0300, 2'b10, "R5");
    acc(0, 1, 3, 16'h0090, 2'b10, "R5");
    acc(0, 0, 2, 16'h0800, 2'b01, "R6");
    acc(1, 0, 3, 16'h01FF, 2'b10, "R6");
    wr(1, 4, 24'h123456, 17'h00020, 3'b010, "R7");
    acc(1, 0, 4, 16'h001F, 2'b01, "R7");
    acc(1, 0, 4, 16'h0020, 2'b01, "R7");
    wr(1, 0, 24'h001000, 17'h00100, 3'b010, "R7");
    acc(0, 0, 0, 16'h0010, 2'b00, "R7");
    idle("R9");
    idle("R9");
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule